// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block collects up to 32 interrupt request lines and presents them to a processor as two outputs: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each source is configured independently through a small register file. The configuration chooses how the line is sensed (rising edge or level), its arbitration priority, and which of the two outputs it competes for. A global mask register can hold any source back from arbitration while its pending bit keeps recording.

When an output is idle and at least one unmasked, pending source is routed to it, the block picks a winner and asserts the output on the next clock. It records the winner's number in a read-only register and then freezes both the output and that number. Software reads the number, services the source and writes an acknowledge bit to the control register. The acknowledge drops the output and, for an edge source, clears the winner's pending bit. Arbitration then resumes on the following cycle. A build parameter states whether this bank may drive the fast output at all. Banks that may not force every source onto the normal output.

The register port is plain: a write strobe or a read strobe with an address. A write takes effect at the clock edge that samples it. Read data appears on `reg_rdata` one clock after the read strobe and holds until the next read.

Top module: `irqc_bank`

## Requirements
- R1: After reset every mask bit (offset 0x04) reads 1, the pending register (offset 0x00) and every configuration word read 0, and `irq_o` and `fiq_o` are low.
- R2: A mask bit of 1 keeps its source out of arbitration, while its pending bit still records. A mask bit of 0 lets the source compete.
- R3: The configuration word of source n sits at offset 0x1C + 4·n. Bit 0 routes the source to the fast output, bit 1 selects level sensing (1) or rising-edge sensing (0), and bits 6:2 hold the priority. The word reads back as written.
- R4: An edge-sensed source sets its pending bit on a rising input edge and keeps it set after the input falls.
- R5: A level-sensed source's pending bit follows its input one clock later, set while the input is high and clear while it is low.
- R6: Writing the pending register clears every edge-sensed pending bit whose written data bit is 0. A written 1 leaves the bit unchanged.
- R7: Among candidates for one output, the lowest priority value wins, and equal values go to the lowest source index.
- R8: An output rises one clock after an unmasked, pending source routed to it exists. The winner number (normal at 0x10, fast at 0x14) and the output then stay unchanged until acknowledged, even if a better source arrives.
- R9: Writing the control register (offset 0x18) with bit 0 set acknowledges the normal output, and bit 1 acknowledges the fast output. The output drops at that edge, the winner's pending bit clears if the winner is edge-sensed, and the other output is unaffected.
- R10: With `FIQ_CAPABLE` = 0 the fast-routing bit reads 0, `fiq_o` never rises, and every source competes for `irq_o`.
- R11: Read data for the register addressed with `reg_rd` is on `reg_rdata` one clock later. The control register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one clock after `reg_rd` |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |

## Verification
The bench instantiates the bank twice on shared stimulus. The first instance uses the defaults (32 sources, `FIQ_CAPABLE` = 1), which exercises both outputs together, independent acknowledges and the full priority and tie-break ordering. The second instance sets `FIQ_CAPABLE` = 0. On that instance the same fast-routed configuration must read back with bit 0 cleared, and the source must win the normal output instead, so the forced-routing path is reachable only there.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int DATA_W = 32;
  localparam int PRIO_W = 5;

  // Register byte offsets
  localparam int OFF_PEND   = 'h00;
  localparam int OFF_MASK   = 'h04;
  localparam int OFF_IRQNUM = 'h10;
  localparam int OFF_FIQNUM = 'h14;
  localparam int OFF_CTRL   = 'h18;
  localparam int OFF_CFG0   = 'h1C;
  localparam int CFG_STRIDE = 4;

  // Per-source configuration word, bits [6:0]
  typedef struct packed {
    logic [PRIO_W-1:0] prio;     // [6:2]
    logic              level;    // [1]  1 = level, 0 = rising edge
    logic              to_fiq;   // [0]  route to fast output
  } src_cfg_t;

  localparam int CFG_W = $bits(src_cfg_t);

endpackage

// File: rtl/irqc_src_slice.sv
module irqc_src_slice
  import irqc_pkg::*;
#(
  parameter bit FIQ_CAPABLE = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     src_in,
  input  logic     cfg_we,
  input  src_cfg_t cfg_wdata,
  input  logic     pend_clr,
  output src_cfg_t cfg,
  output logic     pend
);

  logic     src_q;
  src_cfg_t cfg_q;
  logic     pend_q;
  logic     rise;

  assign rise = src_in & ~src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      src_q <= src_in;
      if (cfg_we) begin
        cfg_q.prio   <= cfg_wdata.prio;
        cfg_q.level  <= cfg_wdata.level;
        cfg_q.to_fiq <= FIQ_CAPABLE ? cfg_wdata.to_fiq : 1'b0;
      end
    end
  end

  // Level sources track the line; edge sources latch until cleared.
  // A new edge in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (cfg_q.level) begin
      pend_q <= src_in;
    end else if (rise) begin
      pend_q <= 1'b1;
    end else if (pend_clr) begin
      pend_q <= 1'b0;
    end
  end

  assign cfg  = cfg_q;
  assign pend = pend_q;

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             req,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           any,
  output logic [SRC_W-1:0]               win
);

  logic [PRIO_W-1:0] best;

  // Strict less-than keeps the lowest index on equal priority.
  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '1;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (req[n] && (!any || prio[n] < best)) begin
        any  = 1'b1;
        win  = SRC_W'(n);
        best = prio[n];
      end
    end
  end

endmodule

// File: rtl/irqc_channel.sv
module irqc_channel #(
  parameter int SRC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any,
  input  logic [SRC_W-1:0] win,
  input  logic             ack,
  output logic             active,
  output logic [SRC_W-1:0] num
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      num    <= '0;
    end else if (!active) begin
      if (any) begin
        active <= 1'b1;
        num    <= win;
      end
    end else if (ack) begin
      active <= 1'b0;
    end
  end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int  NUM_SRC     = 32,
  parameter bit  FIQ_CAPABLE = 1'b1,
  localparam int SRC_W       = $clog2(NUM_SRC),
  localparam int ADDR_W      = $clog2(OFF_CFG0 + CFG_STRIDE * NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o,
  output logic               fiq_o
);

  // ---------------- decode ----------------
  logic wr_pend, wr_mask, wr_ctrl;
  logic irq_ack, fiq_ack;
  logic [NUM_SRC-1:0] cfg_sel;

  assign wr_pend = reg_wr && (reg_addr == ADDR_W'(OFF_PEND));
  assign wr_mask = reg_wr && (reg_addr == ADDR_W'(OFF_MASK));
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
  assign irq_ack = wr_ctrl && reg_wdata[0];
  assign fiq_ack = wr_ctrl && reg_wdata[1];

  // ---------------- mask ----------------
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (wr_mask) mask_q <= reg_wdata[NUM_SRC-1:0];
  end

  // ---------------- channel state ----------------
  logic             irq_active, fiq_active;
  logic [SRC_W-1:0] irq_num, fiq_num;

  // ---------------- sources ----------------
  src_cfg_t [NUM_SRC-1:0]             cfg_v;
  logic     [NUM_SRC-1:0]             pend_v;
  logic     [NUM_SRC-1:0]             route_fiq;
  logic     [NUM_SRC-1:0][PRIO_W-1:0] prio_v;
  logic     [NUM_SRC-1:0]             pend_clr;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    assign cfg_sel[n] = (reg_addr == ADDR_W'(OFF_CFG0 + CFG_STRIDE * n));

    assign pend_clr[n] = (wr_pend && !reg_wdata[n])
                       || (irq_active && irq_ack && irq_num == SRC_W'(n))
                       || (fiq_active && fiq_ack && fiq_num == SRC_W'(n));

    irqc_src_slice #(.FIQ_CAPABLE(FIQ_CAPABLE)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_in   (src_in[n]),
      .cfg_we   (reg_wr && cfg_sel[n]),
      .cfg_wdata(src_cfg_t'(reg_wdata[CFG_W-1:0])),
      .pend_clr (pend_clr[n]),
      .cfg      (cfg_v[n]),
      .pend     (pend_v[n])
    );

    assign route_fiq[n] = cfg_v[n].to_fiq;
    assign prio_v[n]    = cfg_v[n].prio;
  end

  // ---------------- arbitration ----------------
  logic [NUM_SRC-1:0] live;
  logic [NUM_SRC-1:0] irq_req, fiq_req;
  logic               irq_any, fiq_any;
  logic [SRC_W-1:0]   irq_win, fiq_win;

  assign live    = pend_v & ~mask_q;
  assign irq_req = live & ~route_fiq;
  assign fiq_req = live &  route_fiq;

  irqc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb_irq (
    .req (irq_req),
    .prio(prio_v),
    .any (irq_any),
    .win (irq_win)
  );

  irqc_channel #(.SRC_W(SRC_W)) u_ch_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .any   (irq_any),
    .win   (irq_win),
    .ack   (irq_ack),
    .active(irq_active),
    .num   (irq_num)
  );

  if (FIQ_CAPABLE) begin : g_fiq
    irqc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb_fiq (
      .req (fiq_req),
      .prio(prio_v),
      .any (fiq_any),
      .win (fiq_win)
    );

    irqc_channel #(.SRC_W(SRC_W)) u_ch_fiq (
      .clk   (clk),
      .rst_n (rst_n),
      .any   (fiq_any),
      .win   (fiq_win),
      .ack   (fiq_ack),
      .active(fiq_active),
      .num   (fiq_num)
    );
  end else begin : g_no_fiq
    logic unused_fiq;
    assign unused_fiq = |fiq_req;
    assign fiq_any    = 1'b0;
    assign fiq_win    = '0;
    assign fiq_active = 1'b0;
    assign fiq_num    = '0;
  end

  assign irq_o = irq_active;
  assign fiq_o = fiq_active;

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (reg_addr == ADDR_W'(OFF_PEND))   rd_val[NUM_SRC-1:0] = pend_v;
    if (reg_addr == ADDR_W'(OFF_MASK))   rd_val[NUM_SRC-1:0] = mask_q;
    if (reg_addr == ADDR_W'(OFF_IRQNUM)) rd_val[SRC_W-1:0]   = irq_num;
    if (reg_addr == ADDR_W'(OFF_FIQNUM)) rd_val[SRC_W-1:0]   = fiq_num;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (cfg_sel[n]) rd_val[CFG_W-1:0] = cfg_v[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

endmodule

// File: rtl/irqc_bank_chk.sv
module irqc_bank_chk #(
  parameter int NUM_SRC     = 32,
  parameter bit FIQ_CAPABLE = 1'b1,
  parameter int ADDR_W      = 8,
  parameter int SRC_W       = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [1:0]         ctrl_bits,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [SRC_W-1:0]   irq_num,
  input logic [SRC_W-1:0]   fiq_num
);

  logic ctrl_wr, ack_i, ack_f;
  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(8'h18));
  assign ack_i   = ctrl_wr && ctrl_bits[0];
  assign ack_f   = ctrl_wr && ctrl_bits[1];

  // R1: state seen on the first edge after reset release
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask_q == '1 && !irq_o && !fiq_o));

  // R2: the captured winner was unmasked on the cycle it was chosen
  a_r2_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ((($past(mask_q) >> irq_num) & NUM_SRC'(1)) == '0));

  // R8: output and number frozen until acknowledged
  a_r8_irq_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> (irq_o && $stable(irq_num)));

  a_r8_fiq_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && !ack_f) |=> (fiq_o && $stable(fiq_num)));

  // R9: acknowledge drops the output at that edge
  a_r9_irq_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |=> !irq_o);

  a_r9_fiq_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && ack_f) |=> !fiq_o);

  // R10: a bank without fast routing never raises the fast output
  if (!FIQ_CAPABLE) begin : g_nf
    a_r10_fiq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !fiq_o);
  end

endmodule

bind irqc_bank irqc_bank_chk #(
  .NUM_SRC    (NUM_SRC),
  .FIQ_CAPABLE(FIQ_CAPABLE),
  .ADDR_W     (ADDR_W),
  .SRC_W      (SRC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .ctrl_bits(reg_wdata[1:0]),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .mask_q   (mask_q),
  .irq_num  (irq_num),
  .fiq_num  (fiq_num)
);

// File: tb/irqc_bank_tb.sv
module irqc_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_nf;
  logic        irq, fiq, irq_nf, fiq_nf;

  always #10 clk = ~clk;   // 50 MHz

  irqc_bank u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  irqc_bank #(.FIQ_CAPABLE(1'b0)) u_dut_nf (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_nf),
    .irq_o(irq_nf), .fiq_o(fiq_nf)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  localparam logic [7:0] A_PEND = 8'h00, A_MASK = 8'h04, A_INUM = 8'h10,
                         A_FNUM = 8'h14, A_CTRL = 8'h18, A_CFG0 = 8'h1C;

  function automatic logic [7:0] cfg_a(int n);
    return A_CFG0 + 8'(4 * n);
  endfunction

  function automatic logic [31:0] cfgw(int prio, bit lvl, bit f);
    return 32'((prio << 2) | (int'(lvl) << 1) | int'(f));
  endfunction

  // ---------------- driver ----------------
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pchk(logic [31:0] act, logic [31:0] e, string tag);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, e);
    end
  endtask

  task automatic pulse(logic [31:0] bits);
    @(negedge clk); src_in = src_in | bits;
    @(negedge clk); src_in = src_in & ~bits;
  endtask

  // ---------------- monitor ----------------
  initial begin
    forever begin
      bit seen;
      @(posedge clk);
      seen = reg_rd;
      @(negedge clk);
      if (seen) begin
        item_t it;
        if (q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R11: read data 0x%0h with no expected item", rdata);
        end else begin
          it = q.pop_front();
          pchk(rdata, it.exp, it.tag);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    pchk({31'b0, irq}, 32'h0, "R1 irq_o after reset");
    pchk({31'b0, fiq}, 32'h0, "R1 fiq_o after reset");
    rd(A_MASK, 32'hFFFF_FFFF, "R1 mask after reset");
    rd(A_PEND, 32'h0, "R1 pending after reset");
    rd(cfg_a(5), 32'h0, "R1 cfg after reset");

    // R3 config layout and readback; R10 forced routing bit
    wr(cfg_a(5), cfgw(9, 1, 1));
    rd(cfg_a(5), 32'h27, "R3 cfg readback");
    pchk(rdata_nf, 32'h26, "R10 fiq bit forced to 0");
    wr(cfg_a(5), 32'h0);

    // R4 edge latch while masked; R2 masked source stays quiet
    pulse(32'h8);
    idle(2);
    rd(A_PEND, 32'h8, "R4 edge pending held");
    pchk({31'b0, irq}, 32'h0, "R2 masked source no irq");

    // R6 pending write semantics
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, 32'h8, "R6 write 1 leaves pending");
    wr(A_PEND, ~32'h8);
    rd(A_PEND, 32'h0, "R6 write 0 clears pending");

    // R5 level tracking
    wr(cfg_a(7), cfgw(0, 1, 0));
    @(negedge clk); src_in[7] = 1'b1;
    idle(2);
    rd(A_PEND, 32'h80, "R5 level pending high");
    @(negedge clk); src_in[7] = 1'b0;
    idle(2);
    rd(A_PEND, 32'h0, "R5 level pending low");

    // R2/R8 unmask raises irq one clock later
    pulse(32'h8);
    wr(A_MASK, ~32'h8);
    pchk({31'b0, irq}, 32'h0, "R8 irq not before one clock");
    idle(1);
    pchk({31'b0, irq}, 32'h1, "R2 unmasked source raises irq");
    rd(A_INUM, 32'd3, "R8 irq number");

    // R8 frozen while a better source arrives
    wr(cfg_a(1), cfgw(0, 0, 0));
    wr(A_MASK, ~32'hA);
    pulse(32'h2);
    idle(2);
    rd(A_INUM, 32'd3, "R8 number frozen");
    pchk({31'b0, irq}, 32'h1, "R8 irq held");

    // R9 ack drops output and clears edge winner
    wr(A_CTRL, 32'h1);
    pchk({31'b0, irq}, 32'h0, "R9 irq dropped by ack");
    idle(1);
    pchk({31'b0, irq}, 32'h1, "R9 next source raises irq");
    rd(A_INUM, 32'd1, "R9 next winner number");
    rd(A_PEND, 32'h2, "R9 ack cleared edge winner only");
    wr(A_CTRL, 32'h1);
    idle(2);
    pchk({31'b0, irq}, 32'h0, "R9 all serviced");
    rd(A_PEND, 32'h0, "R9 pending empty");

    // R7 priority and tie-break
    wr(A_MASK, 32'hFFFF_FFFF);
    wr(cfg_a(4),  cfgw(6, 0, 0));
    wr(cfg_a(9),  cfgw(2, 0, 0));
    wr(cfg_a(12), cfgw(2, 0, 0));
    pulse(32'h1210);
    wr(A_MASK, ~32'h1210);
    idle(1);
    rd(A_INUM, 32'd9, "R7 lowest value, lowest index");
    wr(A_CTRL, 32'h1);
    idle(2);
    rd(A_INUM, 32'd12, "R7 tie partner next");
    wr(A_CTRL, 32'h1);
    idle(2);
    rd(A_INUM, 32'd4, "R7 highest value last");
    wr(A_CTRL, 32'h1);
    idle(2);
    pchk({31'b0, irq}, 32'h0, "R7 queue drained");

    // R9/R10 fast output and independent acknowledges
    wr(A_MASK, 32'hFFFF_FFFF);
    wr(cfg_a(20), cfgw(1, 0, 1));
    wr(cfg_a(21), cfgw(3, 0, 0));
    pulse(32'h30_0000);
    wr(A_MASK, ~32'h30_0000);
    idle(1);
    pchk({31'b0, fiq}, 32'h1, "R8 fiq raised");
    pchk({31'b0, irq}, 32'h1, "R8 irq raised with fiq");
    pchk({31'b0, fiq_nf}, 32'h0, "R10 no fiq without capability");
    pchk({31'b0, irq_nf}, 32'h1, "R10 fiq source drives irq");
    rd(A_FNUM, 32'd20, "R8 fiq number");
    rd(A_INUM, 32'd21, "R8 irq number beside fiq");
    pchk(rdata_nf, 32'd20, "R10 forced source wins irq");
    wr(A_CTRL, 32'h2);
    pchk({31'b0, fiq}, 32'h0, "R9 fiq ack");
    pchk({31'b0, irq}, 32'h1, "R9 irq untouched by fiq ack");
    wr(A_CTRL, 32'h3);
    pchk({31'b0, irq}, 32'h0, "R9 combined ack");

    // R11 control register reads zero
    rd(A_CTRL, 32'h0, "R11 control reads zero");

    idle(4);
    finish_run();
  end

endmodule